// File: doc/BRIEF.md
# Countdown System Tick Timer

This block is a single down-counting timer for a system tick. It sits behind a small register bus and has two words: a control word and a count word. Software arms the timer by first setting the run bit, then writing a number of ticks into the count word. The counter loses one each time the tick strobe is high. When it reaches zero it latches a pending event and, if the interrupt is allowed, drives the interrupt line.

The run bit gates everything that moves. With it clear the counter is frozen, writes to the count word are dropped and the interrupt permission cannot be raised. A write of all zeros to the control word therefore both halts the timer and masks its interrupt. The pending event is removed by writing a one to a control bit that clears itself and never reads back as one.

Top module: `tick_countdown_timer`

## Requirements
- R1: After reset the count word reads 0, the control word reads 0 and `irqOut` is low.
- R2: The control word is at byte offset 0x40. Bit 0 is the run bit and bit 1 is the interrupt permission; both read back. Bit 4 and all other bits read as 0.
- R3: With the run bit set, a write to the count word at offset 0x44 loads the written value, and a read of 0x44 returns the current count.
- R4: A write to the count word while the run bit is clear leaves the count unchanged.
- R5: In each cycle with `tickEn` high and the run bit set, a nonzero count drops by exactly one. With `tickEn` low or the run bit clear the count holds.
- R6: When a tick takes the count from 1 to 0 the pending event is set. The count then stays at 0 through further ticks until the count word is loaded again.
- R7: `irqOut` is high exactly when the pending event is set and the interrupt permission is set. Masking and unmasking does not clear the pending event.
- R8: A control write with bit 4 set clears the pending event. If an expiry occurs in the same cycle, the expiry wins and the event stays set. Loading the count word does not clear the event.
- R9: A control write with bit 0 clear also clears the interrupt permission, whatever bit 1 holds. A control write with bit 0 set takes bit 1 as the new permission.
- R10: A load of 3 expires on exactly the third tick. A load of 0xFFFFFFFF decrements to 0xFFFFFFFE without wrapping.
- R11: When a count-word load and a tick fall in the same cycle, the loaded value is kept and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Tick strobe, one decrement per high cycle |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Interrupt request, level |

## Verification
A wrong count shows up at once on a read of offset 0x44, so each scenario reads back the count after every load and tick. A pending event that is set wrongly or not at all shows on `irqOut` in the cycle after the expiring tick whenever permission is on. The bench also toggles the permission to expose a hidden event that is set while masked. A lost or stuck permission bit shows on the next read of the control word. The clear-against-expiry race is forced in a single cycle, because a wrong priority there turns into a lost interrupt with no other visible trace.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h40;
  localparam logic [ADDR_W-1:0] COUNT_OFS = 8'h44;
  localparam int RUN_BIT = 0;
  localparam int IRQ_PERMIT_BIT = 1;
  localparam int CLEAR_BIT = 4;

  typedef struct packed {
    logic load;
    logic dec;
    logic clr;
  } tickStrobes_t;
endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output tickStrobes_t      strobes,
  output logic              runReg,
  output logic              irqPermit
);
  logic ctrlWrite;
  logic countWrite;

  assign ctrlWrite  = busSel && busWrite && (busAddr == CTRL_OFS);
  assign countWrite = busSel && busWrite && (busAddr == COUNT_OFS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg    <= 1'b0;
      irqPermit <= 1'b0;
    end else if (ctrlWrite) begin
      runReg    <= busWdata[RUN_BIT];
      irqPermit <= busWdata[RUN_BIT] ? busWdata[IRQ_PERMIT_BIT] : 1'b0;
    end
  end

  always_comb begin
    strobes.load = countWrite && runReg;
    strobes.dec  = tickEn && runReg;
    strobes.clr  = ctrlWrite && busWdata[CLEAR_BIT];
  end

  // R9: a control write with the run bit clear leaves the permission off
  a_r9_permit_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && !busWdata[RUN_BIT]) |=> (!irqPermit && !runReg));

  // R4: with the run bit clear a count write produces no load strobe
  a_r4_no_load_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !runReg |-> !strobes.load);
endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tickStrobes_t      strobes,
  input  logic [DATA_W-1:0] loadValue,
  output logic [DATA_W-1:0] count,
  output logic              pending
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic countZero;
  logic expire;

  assign countZero = (count == '0);
  assign expire    = strobes.dec && !strobes.load && (count == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.load) begin
      count <= loadValue;
    end else if (strobes.dec && !countZero) begin
      count <= count - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (expire) begin
      pending <= 1'b1;
    end else if (strobes.clr) begin
      pending <= 1'b0;
    end
  end

  // R6: zero is sticky without a load
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    (countZero && !strobes.load) |=> (count == '0));

  // R6: the event appears only after a count of one
  a_r6_event_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> ($past(count) == ONE));

  // R11: a load wins over a tick in the same cycle
  a_r11_load_priority: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (count == $past(loadValue)));

  // R5: no strobe, no movement
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.dec) |=> $stable(count));
endmodule

// File: rtl/tick_countdown_timer.sv
module tick_countdown_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [7:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  tickStrobes_t      strobes;
  logic              runReg;
  logic              irqPermit;
  logic [DATA_W-1:0] count;
  logic              pending;

  tick_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .strobes   (strobes),
    .runReg    (runReg),
    .irqPermit (irqPermit)
  );

  tick_datapath #(.DATA_W(DATA_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadValue (busWdata),
    .count     (count),
    .pending   (pending)
  );

  assign irqOut = pending && irqPermit;

  always_comb begin
    busRdata = '0;
    if (busAddr == CTRL_OFS) begin
      busRdata[RUN_BIT]        = runReg;
      busRdata[IRQ_PERMIT_BIT] = irqPermit;
    end else if (busAddr == COUNT_OFS) begin
      busRdata = count;
    end
  end

  // R7: a control write of zero drops the interrupt next cycle
  a_r7_stop_masks_irq: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == CTRL_OFS && busWdata == '0) |=> !irqOut);

  // R2: the clear bit never reads back
  a_r2_clear_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == CTRL_OFS) |-> !busRdata[CLEAR_BIT]);
endmodule

// File: tb/sim_tick_countdown_timer.sv
`timescale 1ns/1ps
module sim_tick_countdown_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick_countdown_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one write cycle, optionally with a tick in the same cycle
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic withTick);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; tickEn = withTick;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; tickEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h44, v); check("R1 count", v, 32'h0);
    rd(8'h40, v); check("R1 ctrl", v, 32'h0);
    check("R1 irq", irqOut, 1'b0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(8'h40, 32'h13, 0);
    rd(8'h40, v); check("R2 ctrl readback", v, 32'h3);
    wr(8'h40, 32'hFFFF_FFF2, 0);
    rd(8'h40, v); check("R9 permit needs run", v, 32'h0);
    wr(8'h40, 32'h1, 0);
    rd(8'h40, v); check("R2 run only", v, 32'h1);
  endtask

  task automatic t_stopped_load();
    logic [31:0] v;
    wr(8'h40, 32'h0, 0);
    wr(8'h44, 32'd100, 0);
    rd(8'h44, v); check("R4 ignored load", v, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(8'h40, 32'h1, 0);
    wr(8'h44, 32'd5, 0);
    rd(8'h44, v); check("R3 load", v, 32'd5);
    ticks(2);
    rd(8'h44, v); check("R5 two ticks", v, 32'd3);
    repeat (4) @(negedge clk);
    rd(8'h44, v); check("R5 no tick hold", v, 32'd3);
    wr(8'h40, 32'h0, 0);
    ticks(2);
    rd(8'h44, v); check("R5 stopped hold", v, 32'd3);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    wr(8'h40, 32'h1, 0);
    wr(8'h44, 32'd3, 0);
    wr(8'h40, 32'h3, 0);
    ticks(2);
    check("R10 no early irq", irqOut, 1'b0);
    ticks(1);
    rd(8'h44, v); check("R6 zero", v, 32'h0);
    check("R10 irq on third tick", irqOut, 1'b1);
    ticks(3);
    rd(8'h44, v); check("R6 no wrap", v, 32'h0);
    wr(8'h40, 32'h1, 0);
    check("R7 masked", irqOut, 1'b0);
    wr(8'h40, 32'h3, 0);
    check("R7 unmask keeps event", irqOut, 1'b1);
    wr(8'h44, 32'd9, 0);
    check("R8 load keeps event", irqOut, 1'b1);
    wr(8'h40, 32'h13, 0);
    check("R8 clear", irqOut, 1'b0);
  endtask

  task automatic t_race();
    wr(8'h44, 32'd1, 0);
    wr(8'h40, 32'h13, 1);
    check("R8 expiry beats clear", irqOut, 1'b1);
  endtask

  task automatic t_priority_and_max();
    logic [31:0] v;
    wr(8'h44, 32'd10, 0);
    wr(8'h44, 32'd20, 1);
    rd(8'h44, v); check("R11 load over tick", v, 32'd20);
    wr(8'h44, 32'hFFFF_FFFF, 0);
    ticks(1);
    rd(8'h44, v); check("R10 max load", v, 32'hFFFF_FFFE);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(8'h40, 32'h0, 0);
    check("R9 stop masks irq", irqOut, 1'b0);
    rd(8'h40, v); check("R9 ctrl cleared", v, 32'h0);
    ticks(2);
    rd(8'h44, v); check("R9 stopped count", v, 32'hFFFF_FFFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ctrl();
    t_stopped_load();
    t_count();
    t_expire();
    t_race();
    t_priority_and_max();
    t_stop();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule